// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the sync and enable strobes that frame a raster display: horizontal sync, vertical sync, a display-enable window, a narrower active window, and a separate data-valid window for inputs whose pixel stream is shorter than the active width (compressed streams, or a bus carrying two pixels per clock). One pixel counter runs from the first pixel clock of each frame. Every vertical position (sync width, window start and end, frame length) is a count of pixel clocks from frame start, not a line number. A horizontal counter wraps at the programmed line period, and a line counter and a frame counter are brought out for observation.

Timing is programmed through a simple write port into a pending register set. That set is copied into the working set only while the engine is stopped or on the last pixel of a frame, so one frame never mixes old and new timing. A variable-refresh extension can stretch a frame up to a programmed total. In one-shot operation a software trigger can end the frame earlier, but no earlier than the normal frame length.

Top module: `disp_timing_gen`

## Requirements
- R1: The horizontal counter runs from 0 to P-1, where P is bits 31:16 of the word at address 0. hsync is asserted (before inversion) while the horizontal counter is below bits 15:0 of that word.
- R2: The frame lasts the pixel-clock count written at address 1. vsync is asserted (before inversion) while the frame pixel counter is below the count written at address 2.
- R3: Display enable is asserted when two conditions hold. The horizontal counter lies within [bits 15:0, bits 31:16] of address 7. The frame pixel counter lies within [address 3, address 4]. Both ranges are inclusive.
- R4: Active enable is asserted when two conditions hold. The horizontal counter lies within [bits 15:0, bits 31:16] of address 8. The frame pixel counter lies within [address 5, address 6]. Both ranges are inclusive.
- R5: Data valid is asserted inside the active vertical range while the horizontal counter is at least the active start and below the active start plus the width in bits 15:0 of address 9. A width of 0 never asserts it.
- R6: At address 10, bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts display enable. Active enable and data valid are never inverted.
- R7: The frame counter counts frames completed since enable. The line counter gives the line index within the current frame. Both read zero whenever the engine is stopped.
- R8: While `en` is low, all raw strobes are deasserted, so outputs sit at their polarity level. When `en` is first sampled high at a clock edge, pixel 0 of frame 0 is presented after that edge.
- R9: A write that lands while the engine runs takes effect at the first pixel of the next frame. The rest of the current frame keeps the old timing.
- R10: Bit 0 of address 11 enables variable refresh. In this mode, unless address 12 has both bit 0 and bit 8 set, every frame lasts the total at address 13 and a trigger has no effect.
- R11: In one-shot variable refresh (address 12 bits 0 and 8 both set), a write to address 14 requests the frame end. The frame then ends on the first pixel at or after the normal last pixel (address 1 minus 1) that follows the trigger. Without a trigger it ends at the address-13 total. A trigger is consumed by the frame end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| disp_en_o | output | 1 | Display enable after polarity |
| act_en_o | output | 1 | Active window enable |
| data_vld_o | output | 1 | Data-valid window |
| frame_cnt_o | output | 16 | Frames completed since enable |
| line_cnt_o | output | 16 | Line index within the frame |

## Verification
All strobes are decoded without further registers from counters that move on each rising edge. A write, an enable change or a trigger sampled at edge N therefore shows in the outputs during the cycle that follows edge N. A trigger becomes eligible to end the frame from the pixel after the one during which it was written. The bench drives inputs on the falling edge. It advances a reference model of the counters and register sets once per rising edge, and compares every output on the following falling edge. Frame lengths under variable refresh are measured from the spacing of frame-counter changes seen at the ports.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  localparam int unsigned HW = 16;
  localparam int unsigned VW = 32;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 32;

  typedef enum logic [AW-1:0] {
    A_HCTL       = 4'd0,
    A_VPERIOD    = 4'd1,
    A_VPULSE     = 4'd2,
    A_DISP_VBEG  = 4'd3,
    A_DISP_VFIN  = 4'd4,
    A_ACT_VBEG   = 4'd5,
    A_ACT_VFIN   = 4'd6,
    A_DISP_HWIN  = 4'd7,
    A_ACT_HWIN   = 4'd8,
    A_DATA_WIDTH = 4'd9,
    A_POLARITY   = 4'd10,
    A_VRR_CTRL   = 4'd11,
    A_VRR_MODE   = 4'd12,
    A_VRR_TOTAL  = 4'd13,
    A_VRR_TRIG   = 4'd14
  } reg_addr_e;

  localparam int unsigned POL_HS  = 0;
  localparam int unsigned POL_VS  = 1;
  localparam int unsigned POL_DE  = 2;
  localparam int unsigned MODE_B0 = 0;
  localparam int unsigned MODE_B1 = 8;

  typedef struct packed {
    logic [HW-1:0] h_period;
    logic [HW-1:0] hs_width;
    logic [HW-1:0] dh_beg;
    logic [HW-1:0] dh_fin;
    logic [HW-1:0] ah_beg;
    logic [HW-1:0] ah_fin;
    logic [HW-1:0] data_w;
    logic [VW-1:0] v_period;
    logic [VW-1:0] vs_pulse;
    logic [VW-1:0] dv_beg;
    logic [VW-1:0] dv_fin;
    logic [VW-1:0] av_beg;
    logic [VW-1:0] av_fin;
    logic [VW-1:0] vrr_total;
    logic [2:0]    pol;
    logic          vrr_en;
    logic          vrr_oneshot;
  } tcfg_t;

endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          running,
  input  logic          load,
  input  logic          frame_end,
  output tcfg_t         cfg_act,
  output logic          trig_pend
);

  tcfg_t pend_q;
  tcfg_t pend_d;
  logic  trig_set;
  logic  trig_d;

  always_comb begin
    pend_d = pend_q;
    if (wr_en) begin
      case (wr_addr)
        A_HCTL: begin
          pend_d.h_period = wr_data[31:16];
          pend_d.hs_width = wr_data[15:0];
        end
        A_VPERIOD:   pend_d.v_period  = wr_data[VW-1:0];
        A_VPULSE:    pend_d.vs_pulse  = wr_data[VW-1:0];
        A_DISP_VBEG: pend_d.dv_beg    = wr_data[VW-1:0];
        A_DISP_VFIN: pend_d.dv_fin    = wr_data[VW-1:0];
        A_ACT_VBEG:  pend_d.av_beg    = wr_data[VW-1:0];
        A_ACT_VFIN:  pend_d.av_fin    = wr_data[VW-1:0];
        A_DISP_HWIN: begin
          pend_d.dh_fin = wr_data[31:16];
          pend_d.dh_beg = wr_data[15:0];
        end
        A_ACT_HWIN: begin
          pend_d.ah_fin = wr_data[31:16];
          pend_d.ah_beg = wr_data[15:0];
        end
        A_DATA_WIDTH: pend_d.data_w    = wr_data[15:0];
        A_POLARITY:   pend_d.pol       = wr_data[2:0];
        A_VRR_CTRL:   pend_d.vrr_en    = wr_data[0];
        A_VRR_MODE:   pend_d.vrr_oneshot = wr_data[MODE_B0] & wr_data[MODE_B1];
        A_VRR_TOTAL:  pend_d.vrr_total = wr_data[VW-1:0];
        default: ;
      endcase
    end
  end

  // A trigger is only recorded while running; it is dropped at a frame end
  // or when the engine stops, and a fresh write wins over the drop.
  always_comb begin
    trig_set = wr_en && (wr_addr == A_VRR_TRIG) && running;
    trig_d   = trig_set | (trig_pend & ~(frame_end | ~running));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      trig_pend <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      trig_pend <= trig_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_act <= '0;
    end else if (load) begin
      cfg_act <= pend_q;
    end
  end

endmodule

// File: rtl/dtg_counter.sv
module dtg_counter #(
  parameter int unsigned HW  = 16,
  parameter int unsigned VW  = 32,
  parameter int unsigned FCW = 16,
  parameter int unsigned LCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [HW-1:0]  h_period,
  input  logic [VW-1:0]  v_period,
  input  logic [VW-1:0]  vrr_total,
  input  logic           vrr_en,
  input  logic           vrr_oneshot,
  input  logic           trig_pend,
  output logic           running,
  output logic [VW-1:0]  pix_cnt,
  output logic [HW-1:0]  h_cnt,
  output logic [LCW-1:0] line_cnt,
  output logic [FCW-1:0] frame_cnt,
  output logic           frame_end
);

  logic           h_last;
  logic           v_last;
  logic           t_last;
  logic           t_early;
  logic           f_last;
  logic           run_d;
  logic [VW-1:0]  pix_d;
  logic [HW-1:0]  h_d;
  logic [LCW-1:0] line_d;
  logic [FCW-1:0] frame_d;

  always_comb begin
    h_last  = (h_cnt == h_period - 1'b1);
    v_last  = (pix_cnt == v_period - 1'b1);
    t_last  = (pix_cnt == vrr_total - 1'b1);
    t_early = trig_pend && (pix_cnt >= v_period - 1'b1);
    if (!vrr_en) begin
      f_last = v_last;
    end else if (vrr_oneshot) begin
      f_last = t_last | t_early;
    end else begin
      f_last = t_last;
    end
    frame_end = running & f_last;
  end

  always_comb begin
    run_d   = running;
    pix_d   = pix_cnt;
    h_d     = h_cnt;
    line_d  = line_cnt;
    frame_d = frame_cnt;
    if (!en) begin
      run_d   = 1'b0;
      pix_d   = '0;
      h_d     = '0;
      line_d  = '0;
      frame_d = '0;
    end else if (!running) begin
      run_d   = 1'b1;
      pix_d   = '0;
      h_d     = '0;
      line_d  = '0;
      frame_d = '0;
    end else if (f_last) begin
      pix_d   = '0;
      h_d     = '0;
      line_d  = '0;
      frame_d = frame_cnt + 1'b1;
    end else begin
      pix_d = pix_cnt + 1'b1;
      if (h_last) begin
        h_d    = '0;
        line_d = line_cnt + 1'b1;
      end else begin
        h_d = h_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      pix_cnt   <= '0;
      h_cnt     <= '0;
      line_cnt  <= '0;
      frame_cnt <= '0;
    end else begin
      running   <= run_d;
      pix_cnt   <= pix_d;
      h_cnt     <= h_d;
      line_cnt  <= line_d;
      frame_cnt <= frame_d;
    end
  end

endmodule

// File: rtl/dtg_decode.sv
module dtg_decode #(
  parameter int unsigned HW = 16,
  parameter int unsigned VW = 32
) (
  input  logic          running,
  input  logic [VW-1:0] pix_cnt,
  input  logic [HW-1:0] h_cnt,
  input  logic [HW-1:0] hs_width,
  input  logic [VW-1:0] vs_pulse,
  input  logic [HW-1:0] dh_beg,
  input  logic [HW-1:0] dh_fin,
  input  logic [HW-1:0] ah_beg,
  input  logic [HW-1:0] ah_fin,
  input  logic [HW-1:0] data_w,
  input  logic [VW-1:0] dv_beg,
  input  logic [VW-1:0] dv_fin,
  input  logic [VW-1:0] av_beg,
  input  logic [VW-1:0] av_fin,
  input  logic [2:0]    pol,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          disp_en_o,
  output logic          act_en_o,
  output logic          data_vld_o
);

  localparam int unsigned XW = HW + 1;

  logic          hs_raw;
  logic          vs_raw;
  logic          disp_h;
  logic          disp_v;
  logic          act_h;
  logic          act_v;
  logic          data_h;
  logic [XW-1:0] data_lim;

  always_comb begin
    hs_raw   = running && (h_cnt < hs_width);
    vs_raw   = running && (pix_cnt < vs_pulse);
    disp_h   = (h_cnt >= dh_beg) && (h_cnt <= dh_fin);
    disp_v   = (pix_cnt >= dv_beg) && (pix_cnt <= dv_fin);
    act_h    = (h_cnt >= ah_beg) && (h_cnt <= ah_fin);
    act_v    = (pix_cnt >= av_beg) && (pix_cnt <= av_fin);
    data_lim = {1'b0, ah_beg} + {1'b0, data_w};
    data_h   = (h_cnt >= ah_beg) && ({1'b0, h_cnt} < data_lim);

    hsync_o    = hs_raw ^ pol[0];
    vsync_o    = vs_raw ^ pol[1];
    disp_en_o  = (running && disp_h && disp_v) ^ pol[2];
    act_en_o   = running && act_h && act_v;
    data_vld_o = running && act_v && data_h;
  end

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int unsigned FCW = 16,
  parameter int unsigned LCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           disp_en_o,
  output logic           act_en_o,
  output logic           data_vld_o,
  output logic [FCW-1:0] frame_cnt_o,
  output logic [LCW-1:0] line_cnt_o
);

  tcfg_t          cfg_act;
  logic           trig_pend;
  logic           running;
  logic           frame_end;
  logic           load;
  logic [VW-1:0]  pix_cnt;
  logic [HW-1:0]  h_cnt;

  assign load = ~running | frame_end;

  dtg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .running   (running),
    .load      (load),
    .frame_end (frame_end),
    .cfg_act   (cfg_act),
    .trig_pend (trig_pend)
  );

  dtg_counter #(.HW(HW), .VW(VW), .FCW(FCW), .LCW(LCW)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .h_period    (cfg_act.h_period),
    .v_period    (cfg_act.v_period),
    .vrr_total   (cfg_act.vrr_total),
    .vrr_en      (cfg_act.vrr_en),
    .vrr_oneshot (cfg_act.vrr_oneshot),
    .trig_pend   (trig_pend),
    .running     (running),
    .pix_cnt     (pix_cnt),
    .h_cnt       (h_cnt),
    .line_cnt    (line_cnt_o),
    .frame_cnt   (frame_cnt_o),
    .frame_end   (frame_end)
  );

  dtg_decode #(.HW(HW), .VW(VW)) u_dec (
    .running    (running),
    .pix_cnt    (pix_cnt),
    .h_cnt      (h_cnt),
    .hs_width   (cfg_act.hs_width),
    .vs_pulse   (cfg_act.vs_pulse),
    .dh_beg     (cfg_act.dh_beg),
    .dh_fin     (cfg_act.dh_fin),
    .ah_beg     (cfg_act.ah_beg),
    .ah_fin     (cfg_act.ah_fin),
    .data_w     (cfg_act.data_w),
    .dv_beg     (cfg_act.dv_beg),
    .dv_fin     (cfg_act.dv_fin),
    .av_beg     (cfg_act.av_beg),
    .av_fin     (cfg_act.av_fin),
    .pol        (cfg_act.pol),
    .hsync_o    (hsync_o),
    .vsync_o    (vsync_o),
    .disp_en_o  (disp_en_o),
    .act_en_o   (act_en_o),
    .data_vld_o (data_vld_o)
  );

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
  parameter int unsigned HW  = 16,
  parameter int unsigned VW  = 32,
  parameter int unsigned FCW = 16,
  parameter int unsigned LCW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           running,
  input logic           act_en_o,
  input logic           data_vld_o,
  input logic [FCW-1:0] frame_cnt_o,
  input logic [LCW-1:0] line_cnt_o,
  input logic [HW-1:0]  h_cnt,
  input logic [HW-1:0]  h_period,
  input logic [VW-1:0]  pix_cnt,
  input logic [VW-1:0]  vrr_total,
  input logic           vrr_en,
  input logic           vrr_oneshot,
  input logic           trig_pend,
  input logic           frame_end
);

  AST_IDLE_COUNTERS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (frame_cnt_o == '0) && (line_cnt_o == '0)); // R7

  AST_DATA_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld_o |-> act_en_o); // R5

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cnt_o != $past(line_cnt_o)) |->
      ((line_cnt_o == $past(line_cnt_o) + 1'b1) || (line_cnt_o == '0))); // R7

  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_cnt_o != $past(frame_cnt_o)) |->
      ((frame_cnt_o == $past(frame_cnt_o) + 1'b1) || (frame_cnt_o == '0))); // R7

  AST_HCNT_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (h_period != '0)) |-> (h_cnt < h_period)); // R1

  AST_EARLY_END_TRIGGERED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && vrr_en && vrr_oneshot && (pix_cnt != vrr_total - 1'b1)) |-> trig_pend); // R11

endmodule

bind disp_timing_gen dtg_checker #(.HW(dtg_pkg::HW), .VW(dtg_pkg::VW), .FCW(FCW), .LCW(LCW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .running     (running),
  .act_en_o    (act_en_o),
  .data_vld_o  (data_vld_o),
  .frame_cnt_o (frame_cnt_o),
  .line_cnt_o  (line_cnt_o),
  .h_cnt       (h_cnt),
  .h_period    (cfg_act.h_period),
  .pix_cnt     (pix_cnt),
  .vrr_total   (cfg_act.vrr_total),
  .vrr_en      (cfg_act.vrr_en),
  .vrr_oneshot (cfg_act.vrr_oneshot),
  .trig_pend   (trig_pend),
  .frame_end   (frame_end)
);

// File: tb/disp_timing_gen_tb.sv
module disp_timing_gen_tb;
  import dtg_pkg::*;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          hsync_o, vsync_o, disp_en_o, act_en_o, data_vld_o;
  logic [15:0]   frame_cnt_o, line_cnt_o;

  always #10 clk = ~clk;

  disp_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .disp_en_o(disp_en_o), .act_en_o(act_en_o), .data_vld_o(data_vld_o),
    .frame_cnt_o(frame_cnt_o), .line_cnt_o(line_cnt_o)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;
  logic [31:0] m_pend [16];
  logic [31:0] m_act  [16];
  bit          run_m = 0;
  bit          trig_m = 0;
  int unsigned p = 0;
  int unsigned frame_m = 0;
  logic [15:0] prev_fc = '0;
  int          cyc = 0;
  int          meas_len = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit last_m();
    logic [31:0] vp, vt;
    bit oneshot;
    vp = m_act[1];
    vt = m_act[13];
    oneshot = m_act[12][0] && m_act[12][8];
    if (!m_act[11][0]) return p == vp - 1;
    if (oneshot) return (p == vt - 1) || ((p >= vp - 1) && trig_m);
    return p == vt - 1;
  endfunction

  task automatic model_edge();
    bit fe, ld, tset;
    fe   = run_m && last_m();
    ld   = !run_m || fe;
    tset = wr_en && (wr_addr == 4'd14) && run_m;
    trig_m = tset ? 1'b1 : ((fe || !run_m) ? 1'b0 : trig_m);
    if (ld) m_act = m_pend;
    if (wr_en) m_pend[wr_addr] = wr_data;
    if (!en) begin
      run_m = 0; p = 0; frame_m = 0;
    end else if (!run_m) begin
      run_m = 1; p = 0; frame_m = 0;
    end else if (fe) begin
      p = 0; frame_m++;
    end else begin
      p++;
    end
  endtask

  task automatic compare(string ctx);
    int unsigned hper, h, ln;
    bit hs, vs, de, ae, dv;
    logic [2:0] pol;
    hper = m_act[0][31:16];
    h  = (run_m && hper != 0) ? p % hper : 0;
    ln = (run_m && hper != 0) ? p / hper : 0;
    pol = m_act[10][2:0];
    hs = run_m && (h < m_act[0][15:0]);
    vs = run_m && (p < m_act[2]);
    de = run_m && (h >= m_act[7][15:0]) && (h <= m_act[7][31:16]) &&
         (p >= m_act[3]) && (p <= m_act[4]);
    ae = run_m && (h >= m_act[8][15:0]) && (h <= m_act[8][31:16]) &&
         (p >= m_act[5]) && (p <= m_act[6]);
    dv = run_m && (p >= m_act[5]) && (p <= m_act[6]) &&
         (h >= m_act[8][15:0]) && (h < m_act[8][15:0] + m_act[9][15:0]);
    chk({"R1 ", ctx}, "hsync", hsync_o, hs ^ pol[0]);
    chk({"R2 ", ctx}, "vsync", vsync_o, vs ^ pol[1]);
    chk({"R3 ", ctx}, "disp_en", disp_en_o, de ^ pol[2]);
    chk({"R4 ", ctx}, "act_en", act_en_o, ae);
    chk({"R5 ", ctx}, "data_vld", data_vld_o, dv);
    chk({"R7 ", ctx}, "frame_cnt", frame_cnt_o, frame_m & 16'hffff);
    chk({"R7 ", ctx}, "line_cnt", line_cnt_o, ln & 16'hffff);
    if (frame_cnt_o != prev_fc) begin
      meas_len = cyc;
      cyc = 0;
      prev_fc = frame_cnt_o;
    end
    cyc++;
  endtask

  task automatic tick(string ctx);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    wr_en = 1'b0;
    compare(ctx);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, string ctx);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    tick(ctx);
  endtask

  task automatic run(int n, string ctx);
    for (int i = 0; i < n; i++) tick(ctx);
  endtask

  task automatic run_to(int unsigned pv, string ctx);
    for (int i = 0; i < 400; i++) begin
      tick(ctx);
      if (run_m && p == pv) break;
    end
  endtask

  task automatic t_reset();
    chk("R8", "reset hsync", hsync_o, 0);
    chk("R8", "reset vsync", vsync_o, 0);
    chk("R8", "reset disp_en", disp_en_o, 0);
    chk("R7", "reset frame_cnt", frame_cnt_o, 0);
    chk("R7", "reset line_cnt", line_cnt_o, 0);
  endtask

  task automatic t_basic();
    wr(4'd0, {16'd10, 16'd2}, "cfg");
    wr(4'd1, 32'd60, "cfg");
    wr(4'd2, 32'd10, "cfg");
    wr(4'd3, 32'd20, "cfg");
    wr(4'd4, 32'd49, "cfg");
    wr(4'd5, 32'd20, "cfg");
    wr(4'd6, 32'd39, "cfg");
    wr(4'd7, {16'd7, 16'd4}, "cfg");
    wr(4'd8, {16'd8, 16'd5}, "cfg");
    wr(4'd9, 32'd2, "cfg");
    run(2, "R8 idle");
    en = 1'b1;
    tick("R8 start");
    chk("R8", "first pixel line", line_cnt_o, 0);
    chk("R1", "first pixel hsync", hsync_o, 1);
    run(140, "R2 basic");
    chk("R2", "frame length", meas_len, 60);
  endtask

  task automatic t_boundary();
    run_to(25, "R9");
    wr(4'd0, {16'd10, 16'd3}, "R9 write");
    wr(4'd9, 32'd3, "R9 write");
    run_to(32, "R9");
    chk("R9", "old hsync width kept", hsync_o, 0);
    run_to(2, "R9");
    chk("R9", "new hsync width used", hsync_o, 1);
    run(70, "R9 after");
  endtask

  task automatic t_polarity();
    wr(4'd10, 32'd7, "R6 write");
    wr(4'd9, 32'd0, "R5 zero width");
    run_to(0, "R6");
    chk("R6", "inverted hsync at pixel0", hsync_o, 0);
    chk("R6", "inverted vsync at pixel0", vsync_o, 0);
    run(130, "R6 inverted");
    wr(4'd10, 32'd0, "R6 restore");
    wr(4'd9, 32'd2, "R5 restore");
    run_to(0, "R6");
  endtask

  task automatic t_vrr_cont();
    wr(4'd13, 32'd80, "R10 write");
    wr(4'd12, 32'h001, "R10 write");
    wr(4'd11, 32'd1, "R10 write");
    run_to(0, "R10");
    run_to(15, "R10");
    wr(4'd14, 32'd1, "R10 trigger");
    run_to(0, "R10");
    chk("R10", "stretched frame ignores trigger", meas_len, 80);
  endtask

  task automatic t_vrr_oneshot();
    wr(4'd12, 32'h101, "R11 write");
    run_to(0, "R11");
    run_to(9, "R11");
    wr(4'd14, 32'd1, "R11 early trigger");
    run_to(0, "R11");
    chk("R11", "early trigger held to normal end", meas_len, 60);
    run_to(70, "R11");
    wr(4'd14, 32'd1, "R11 late trigger");
    run_to(0, "R11");
    chk("R11", "late trigger ends frame", meas_len, 72);
    run_to(0, "R11");
    chk("R11", "no trigger runs to total", meas_len, 80);
  endtask

  task automatic t_disable();
    run(5, "R8");
    en = 1'b0;
    tick("R8 stop");
    chk("R7", "stopped frame_cnt", frame_cnt_o, 0);
    chk("R7", "stopped line_cnt", line_cnt_o, 0);
    chk("R8", "stopped data_vld", data_vld_o, 0);
    run(3, "R8 stopped");
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_pend[i] = '0;
      m_act[i]  = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_boundary();
    t_polarity();
    t_vrr_cont();
    t_vrr_oneshot();
    t_disable();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule